// File: doc/BRIEF.md
# SDRAM Power-Up Initialisation Sequencer

This block brings an SDRAM device from an unknown state after reset to a state where normal traffic can begin. A single-cycle start pulse launches a fixed command program on the SDRAM command pins. The program is a precharge of all banks, eight auto-refresh commands and one mode-register load. A mode bit picks where the mode-register load sits: after the eight refreshes, or between the precharge and the refreshes. Different memory vendors expect different orders, so both are offered.

The sequencer takes the CAS latency and the row-active and row-precharge times in clock cycles. These values are captured in the cycle that the start pulse is accepted. Between commands the sequencer drives NOP cycles to honour the precharge time, the refresh cycle time (row-active plus precharge) and a fixed settling time after the mode-register load. It then raises a done flag that stays high until the next reset. The mode word it writes always selects a full-page, sequential burst. The programmed CAS latency goes into the latency field of that word.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and after reset until a start pulse is accepted, the pins {cs_n, ras_n, cas_n, we_n} carry NOP = 4'b0111, the address bus is zero and init_done_o is low.
- R2: With order_sel_i = 0 at start, the commands issued are PREA, then eight REF, then MRS.
- R3: With order_sel_i = 1 at start, the commands issued are PREA, then MRS, then eight REF.
- R4: PREA is driven as pins 4'b0010 with address bit 10 high and every other address bit low. It appears in the first cycle after the clock edge that accepts the start pulse.
- R5: Exactly trp_i NOP cycles follow PREA before the next command. A value of 0 gives no NOP.
- R6: REF is driven as pins 4'b0001 with a zero address. Each REF is followed by max(tras_i + trp_i, 1) - 1 NOP cycles, including the last REF. Consecutive REFs are therefore at least tras_i + trp_i cycles apart.
- R7: MRS is driven as pins 4'b0000. The address word has [2:0] = 3'b111, [3] = 0, [6:4] = the CAS latency (1 to 3) and [11:7] = 0.
- R8: Exactly two NOP cycles follow MRS before the next command or completion.
- R9: init_done_o rises in the cycle after the last NOP of the final wait. It then stays high with NOP on the pins until reset.
- R10: A start pulse is ignored while the sequence is running and after it has completed.
- R11: cas_lat_i, tras_i, trp_i and order_sel_i are sampled only in the cycle the start pulse is accepted. Later changes have no effect on the sequence.
- R12: cke_o is high in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for the sequence |
| order_sel_i | input | 1 | 0: refreshes before mode load; 1: mode load before refreshes |
| cas_lat_i | input | 2 | CAS latency, 1 to 3 |
| tras_i | input | 4 | Row-active time in cycles |
| trp_i | input | 4 | Row-precharge time in cycles |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | 12 | Address bus |
| cke_o | output | 1 | Clock enable |
| init_done_o | output | 1 | Initialisation complete |

## Verification
The assertions assume that cas_lat_i holds a value from 1 to 3 whenever start is accepted. This is the value the mode-word check relies on. The refresh-spacing check compares against timing fields that the checker captures at the first start after reset, so it does not depend on those fields being held afterwards. The stimulus only ever programs latencies of 1, 2 or 3. It deliberately changes the timing fields and the order bit in the middle of a sequence, and it pulses start again both during a run and after completion.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREA,
        ST_PRE_WAIT,
        ST_REF,
        ST_REF_WAIT,
        ST_MRS,
        ST_MRS_WAIT,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PREA,
        CMD_REF,
        CMD_MRS
    } seq_cmd_e;

    // pin order: {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] PINS_NOP  = 4'b0111;
    localparam logic [3:0] PINS_PREA = 4'b0010;
    localparam logic [3:0] PINS_REF  = 4'b0001;
    localparam logic [3:0] PINS_MRS  = 4'b0000;

endpackage

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         last_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == W'(1));

endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
    parameter int ADDR_W = 12,
    parameter int CL_W   = 2
) (
    input  logic [CL_W-1:0]   cas_lat_i,
    output logic [ADDR_W-1:0] word_o
);

    localparam logic [2:0] BURST_FULL_PAGE = 3'b111;
    localparam logic       BURST_SEQ       = 1'b0;

    always_comb begin
        word_o      = '0;
        word_o[2:0] = BURST_FULL_PAGE;
        word_o[3]   = BURST_SEQ;
        word_o[6:4] = 3'(cas_lat_i);
    end

endmodule

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10
) (
    input  seq_cmd_e          cmd_i,
    input  logic [ADDR_W-1:0] mode_word_i,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [ADDR_W-1:0] addr_o
);

    logic [3:0] pins;

    always_comb begin
        pins   = PINS_NOP;
        addr_o = '0;
        unique case (cmd_i)
            CMD_PREA: begin
                pins           = PINS_PREA;
                addr_o[AP_BIT] = 1'b1;
            end
            CMD_REF: pins = PINS_REF;
            CMD_MRS: begin
                pins   = PINS_MRS;
                addr_o = mode_word_i;
            end
            default: pins = PINS_NOP;
        endcase
    end

    assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = pins;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int CL_W      = 2,
    parameter int TRAS_W    = 4,
    parameter int TRP_W     = 4,
    parameter int REF_COUNT = 8,
    parameter int MRS_WAIT  = 2,
    parameter int AP_BIT    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              order_sel_i,
    input  logic [CL_W-1:0]   cas_lat_i,
    input  logic [TRAS_W-1:0] tras_i,
    input  logic [TRP_W-1:0]  trp_i,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              cke_o,
    output logic              init_done_o
);

    localparam int TIME_W = ((TRAS_W > TRP_W) ? TRAS_W : TRP_W) + 1;
    localparam int REFC_W = $clog2(REF_COUNT + 1);
    localparam logic [REFC_W-1:0] REF_LAST = REFC_W'(REF_COUNT);

    typedef struct packed {
        seq_state_e        state;
        logic              order;
        logic [CL_W-1:0]   cl;
        logic [TRAS_W-1:0] tras;
        logic [TRP_W-1:0]  trp;
        logic [REFC_W-1:0] refs;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              tmr_load;
    logic [TIME_W-1:0] tmr_val;
    logic              tmr_last;
    logic [TIME_W-1:0] rc_cycles;
    logic [TIME_W-1:0] rc_nops;
    logic [REFC_W-1:0] refs_next;
    seq_state_e        after_pre, after_refs, after_mrs;
    seq_cmd_e          cmd;
    logic [ADDR_W-1:0] mode_word;

    always_comb begin
        r_d       = r_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        rc_cycles = TIME_W'(r_q.tras) + TIME_W'(r_q.trp);
        rc_nops   = (rc_cycles == '0) ? '0 : rc_cycles - 1'b1;
        refs_next = r_q.refs + 1'b1;
        after_pre  = r_q.order ? ST_MRS  : ST_REF;
        after_refs = r_q.order ? ST_DONE : ST_MRS;
        after_mrs  = r_q.order ? ST_REF  : ST_DONE;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_PREA;
                    r_d.order = order_sel_i;
                    r_d.cl    = cas_lat_i;
                    r_d.tras  = tras_i;
                    r_d.trp   = trp_i;
                    r_d.refs  = '0;
                end
            end
            ST_PREA: begin
                tmr_load  = 1'b1;
                tmr_val   = TIME_W'(r_q.trp);
                r_d.state = (r_q.trp == '0) ? after_pre : ST_PRE_WAIT;
            end
            ST_PRE_WAIT: begin
                if (tmr_last) begin
                    r_d.state = after_pre;
                end
            end
            ST_REF: begin
                tmr_load = 1'b1;
                tmr_val  = rc_nops;
                r_d.refs = refs_next;
                if (rc_nops != '0) begin
                    r_d.state = ST_REF_WAIT;
                end else begin
                    r_d.state = (refs_next < REF_LAST) ? ST_REF : after_refs;
                end
            end
            ST_REF_WAIT: begin
                if (tmr_last) begin
                    r_d.state = (r_q.refs < REF_LAST) ? ST_REF : after_refs;
                end
            end
            ST_MRS: begin
                tmr_load  = 1'b1;
                tmr_val   = TIME_W'(MRS_WAIT);
                r_d.state = (MRS_WAIT == 0) ? after_mrs : ST_MRS_WAIT;
            end
            ST_MRS_WAIT: begin
                if (tmr_last) begin
                    r_d.state = after_mrs;
                end
            end
            default: r_d.state = ST_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, order: 1'b0, cl: '0, tras: '0, trp: '0, refs: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.state)
            ST_PREA: cmd = CMD_PREA;
            ST_REF:  cmd = CMD_REF;
            ST_MRS:  cmd = CMD_MRS;
            default: cmd = CMD_NOP;
        endcase
    end

    sdram_wait_timer #(
        .W(TIME_W)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .last_o    (tmr_last)
    );

    sdram_mode_word #(
        .ADDR_W(ADDR_W),
        .CL_W  (CL_W)
    ) mode_i (
        .cas_lat_i(r_q.cl),
        .word_o   (mode_word)
    );

    sdram_cmd_decode #(
        .ADDR_W(ADDR_W),
        .AP_BIT(AP_BIT)
    ) decode_i (
        .cmd_i      (cmd),
        .mode_word_i(mode_word),
        .cs_n_o     (cs_n_o),
        .ras_n_o    (ras_n_o),
        .cas_n_o    (cas_n_o),
        .we_n_o     (we_n_o),
        .addr_o     (addr_o)
    );

    // R12: clock enable is never dropped
    assign cke_o       = 1'b1;
    assign init_done_o = (r_q.state == ST_DONE);

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int CL_W      = 2,
    parameter int TRAS_W    = 4,
    parameter int TRP_W     = 4,
    parameter int REF_COUNT = 8,
    parameter int AP_BIT    = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [TRAS_W-1:0] tras_i,
    input logic [TRP_W-1:0]  trp_i,
    input logic              cs_n_o,
    input logic              ras_n_o,
    input logic              cas_n_o,
    input logic              we_n_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              init_done_o
);

    logic [3:0]  pins;
    logic        armed_q;
    logic [15:0] rc_min_q;
    logic [15:0] since_ref_q;
    logic        ref_seen_q;
    logic [7:0]  ref_cnt_q;
    logic [7:0]  mrs_cnt_q;

    assign pins = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q     <= 1'b0;
            rc_min_q    <= '0;
            since_ref_q <= '0;
            ref_seen_q  <= 1'b0;
            ref_cnt_q   <= '0;
            mrs_cnt_q   <= '0;
        end else begin
            if (start_i && !armed_q) begin
                armed_q  <= 1'b1;
                rc_min_q <= 16'(tras_i) + 16'(trp_i);
            end
            if (pins == PINS_REF) begin
                since_ref_q <= 16'd1;
                ref_seen_q  <= 1'b1;
                ref_cnt_q   <= ref_cnt_q + 1'b1;
            end else if (since_ref_q != 16'hFFFF) begin
                since_ref_q <= since_ref_q + 1'b1;
            end
            if (pins == PINS_MRS) begin
                mrs_cnt_q <= mrs_cnt_q + 1'b1;
            end
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> (pins == PINS_NOP && !init_done_o));

    // R4
    prea_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == PINS_PREA) |-> (addr_o == (ADDR_W'(1) << AP_BIT)));

    // R7
    mode_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == PINS_MRS) |-> (addr_o[3:0] == 4'b0111 && addr_o[ADDR_W-1:7] == '0
                                && addr_o[6:4] != 3'd0 && addr_o[6:4] <= 3'd3));

    // R6
    ref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == PINS_REF && ref_seen_q) |-> (since_ref_q >= rc_min_q));

    // R2 R3
    ref_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == PINS_REF) |-> (ref_cnt_q < 8'(REF_COUNT)));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |=> init_done_o);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |-> (pins == PINS_NOP));

    // R9
    done_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done_o) |-> (ref_cnt_q == 8'(REF_COUNT) && mrs_cnt_q == 8'd1));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
    .ADDR_W   (ADDR_W),
    .CL_W     (CL_W),
    .TRAS_W   (TRAS_W),
    .TRP_W    (TRP_W),
    .REF_COUNT(REF_COUNT),
    .AP_BIT   (AP_BIT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .tras_i     (tras_i),
    .trp_i      (trp_i),
    .cs_n_o     (cs_n_o),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .we_n_o     (we_n_o),
    .addr_o     (addr_o),
    .init_done_o(init_done_o)
);

// File: tb/sdram_init_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_init_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        order_sel_i = 1'b0;
    logic [1:0]  cas_lat_i = 2'd1;
    logic [3:0]  tras_i = 4'd0;
    logic [3:0]  trp_i = 4'd0;
    logic        cs_n_o, ras_n_o, cas_n_o, we_n_o, cke_o, init_done_o;
    logic [11:0] addr_o;

    always #5 clk = ~clk;

    sdram_init_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .order_sel_i(order_sel_i),
        .cas_lat_i(cas_lat_i), .tras_i(tras_i), .trp_i(trp_i),
        .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
        .addr_o(addr_o), .cke_o(cke_o), .init_done_o(init_done_o)
    );

    typedef struct {
        logic [3:0]  pins;
        logic [11:0] addr;
        string       tag;
    } exp_t;

    exp_t  exp_q[$];
    bit    started;
    string phase_tag;
    int    checks = 0;
    int    fails = 0;

    function automatic void push(logic [3:0] p, logic [11:0] a, string t);
        exp_t e;
        e.pins = p;
        e.addr = a;
        e.tag  = t;
        exp_q.push_back(e);
    endfunction

    function automatic void add_refs(int tras, int trp, string ord);
        int rc = tras + trp;
        for (int i = 0; i < 8; i++) begin
            push(4'b0001, 12'h000, {ord, " R6"});
            for (int k = 0; k < rc - 1; k++) push(4'b0111, 12'h000, "R6");
        end
    endfunction

    function automatic void add_mrs(int cl, string ord);
        push(4'b0000, {5'b0, 3'(cl), 4'b0111}, {ord, " R7"});
        push(4'b0111, 12'h000, "R8");
        push(4'b0111, 12'h000, "R8");
    endfunction

    function automatic void build(bit ord, int cl, int tras, int trp);
        string o = ord ? "R3" : "R2";
        exp_q.delete();
        push(4'b0010, 12'h400, "R4");
        for (int k = 0; k < trp; k++) push(4'b0111, 12'h000, "R5");
        if (!ord) begin
            add_refs(tras, trp, o);
            add_mrs(cl, o);
        end else begin
            add_mrs(cl, o);
            add_refs(tras, trp, o);
        end
    endfunction

    task automatic compare();
        logic [3:0]  ep;
        logic [11:0] ea;
        logic        ed;
        string       t;
        logic [3:0]  ap;
        if (started && exp_q.size() != 0) begin
            exp_t e = exp_q.pop_front();
            ep = e.pins; ea = e.addr; ed = 1'b0; t = e.tag;
        end else if (started) begin
            ep = 4'b0111; ea = 12'h000; ed = 1'b1; t = "R9";
        end else begin
            ep = 4'b0111; ea = 12'h000; ed = 1'b0; t = "R1";
        end
        ap = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
        checks++;
        if (ap !== ep || addr_o !== ea || init_done_o !== ed || cke_o !== 1'b1) begin
            fails++;
            $display("FAIL %s %s R12: pins=%b addr=%h done=%b cke=%b expected pins=%b addr=%h done=%b cke=1",
                     t, phase_tag, ap, addr_o, init_done_o, cke_o, ep, ea, ed);
        end
    endtask

    task automatic cycle(input logic st);
        @(negedge clk);
        compare();
        start_i = st;
        if (st && !started) begin
            build(order_sel_i, int'(cas_lat_i), int'(tras_i), int'(trp_i));
            started = 1'b1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start_i = 1'b0;
        started = 1'b0;
        exp_q.delete();
        phase_tag = "";
        cycle(1'b0);
        cycle(1'b0);
        rst_n = 1'b1;
    endtask

    task automatic run(bit ord, int cl, int tras, int trp);
        do_reset();
        repeat (3) cycle(1'b0);
        order_sel_i = ord;
        cas_lat_i   = 2'(cl);
        tras_i      = 4'(tras);
        trp_i       = 4'(trp);
        cycle(1'b1);
        cycle(1'b0);
        // R11: scramble the fields after acceptance
        order_sel_i = ~ord;
        cas_lat_i   = 2'd3 - 2'(cl) + 2'd1;
        tras_i      = 4'd15;
        trp_i       = 4'd15;
        phase_tag   = "R11";
        cycle(1'b0);
        cycle(1'b0);
        // R10: start while running
        phase_tag = "R10 R11";
        cycle(1'b1);
        cycle(1'b0);
        while (exp_q.size() != 0) cycle(1'b0);
        repeat (3) cycle(1'b0);
        // R10: start after completion
        cycle(1'b1);
        repeat (4) cycle(1'b0);
    endtask

    bit timed_out = 1'b0;

    initial begin
        fork
            begin
                run(1'b0, 2, 3, 2);
                run(1'b1, 3, 1, 1);
                run(1'b0, 1, 1, 0);
                run(1'b1, 1, 0, 3);
            end
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule